// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address after a miss in the translation buffer. It fetches a first-level descriptor from memory, and if that descriptor points to a second-level table it fetches a second descriptor. It then returns the physical address with the permission, domain, attribute, execute-never, shareable and global fields. When no valid mapping exists it returns a fault code instead. Each result carries the context tag and the write and fetch flags of the request that caused it.

Requests that arrive while a walk is running wait in an in-order queue. A squash input marks every waiting request of one context as dead. Dead requests are never walked and produce no response, and at most `MAX_DROP` of them leave the head of the queue per cycle. When a mapping descriptor is used and its access flag is clear, the walker writes the descriptor back with the flag set before it reports the result.

Memory is reached through one read/write request port. That port allows one access outstanding at a time, and every access, read or write, is acknowledged by one response pulse.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high while fewer than `QDEPTH` requests wait. A request is accepted when `req_valid` and `req_ready` are both high. Accepted requests are walked in arrival order, and each response carries the `ctx`, write and fetch values of its request.
- R2: The first-level descriptor is read from `{ttb_base[31:14-BASE_N], va[31-BASE_N:20], 2'b00}`.
- R3: A first-level descriptor whose bits [1:0] are 0 or 3 ends the walk with `rsp_fault` = 1. In that case no second read is made, and the address and all field outputs are 0.
- R4: First-level type 2 with bit 18 clear is a 1 MB section. The outputs are: address `{d[31:20], va[19:0]}`, ap `{d[15], d[11], 1}`, domain `d[8:5]`, xn `d[4]`, global `d[17]`, shareable `d[16]`, attr `{d[14:12], d[3], d[2]}`, and fault 0.
- R5: A type 2 descriptor with bit 18 set ends the walk with `rsp_fault` = 3 (unsupported) and zero fields.
- R6: First-level type 1 is a table pointer. The second descriptor is read from `{d1[31:10], va[19:12], 2'b00}`. A second descriptor with bits [1:0] = 0 ends the walk with `rsp_fault` = 2.
- R7: A second descriptor with bit 1 = 0 and bit 0 = 1 is a 64 KB page. The outputs are: address `{d[31:16], va[15:0]}`, xn `d[15]`, attr `{d[14:12], d[3], d[2]}`.
- R8: A second descriptor with bit 1 = 1 is a 4 KB page. The outputs are: address `{d[31:12], va[11:0]}`, xn `d[0]`, attr `{d[8:6], d[3], d[2]}`. For both second-level page kinds: ap `{d[9], d[5], 1}`, global `!d[11]`, shareable `d[10]`, and domain taken from first-level bits [8:5].
- R9: If the mapping descriptor's access flag is 0, the descriptor with the flag set is written back to the address it was read from before the response. The flag is bit 10 at first level and bit 4 at second level. No write is made when the flag is already set.
- R10: `squash_valid` with `squash_ctx` marks every waiting request of that context. Marked requests are never walked and give no response. At most `MAX_DROP` of them are removed per cycle. A walk already in progress is not affected.
- R11: `rsp_valid` is a one-cycle pulse per walk. `mem_req_valid` is a one-cycle pulse per access, and only one access is outstanding at a time.
- R12: After reset, `rsp_valid` and `mem_req_valid` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ttb_base | input | 32 | Base address of the first-level table |
| req_valid | input | 1 | Walk request strobe |
| req_ready | output | 1 | Queue has room |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_ctx | input | CTX_W | Context tag |
| squash_valid | input | 1 | Squash strobe |
| squash_ctx | input | CTX_W | Context whose waiting requests are squashed |
| mem_req_valid | output | 1 | Memory access strobe |
| mem_req_write | output | 1 | Access is a descriptor write-back |
| mem_req_addr | output | 32 | Descriptor address |
| mem_req_wdata | output | 32 | Write-back data |
| mem_rsp_valid | input | 1 | Memory acknowledge / read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Result strobe |
| rsp_ctx | output | CTX_W | Context tag of the result |
| rsp_write | output | 1 | Store flag of the request |
| rsp_fetch | output | 1 | Fetch flag of the request |
| rsp_fault | output | 2 | 0 none, 1 first-level, 2 second-level, 3 unsupported |
| rsp_paddr | output | 32 | Physical address |
| rsp_ap | output | 3 | Access permission |
| rsp_domain | output | 4 | Domain |
| rsp_xn | output | 1 | Execute-never |
| rsp_global | output | 1 | Global mapping |
| rsp_share | output | 1 | Shareable |
| rsp_attr | output | 5 | Memory attribute code |

## Verification
The hardest situation to reach from the ports is a squash that lands on a queue holding a mix of live and dead requests. It is hard because an idle walker empties the queue on the next cycle. The bench stretches the memory latency to 20 cycles so that the first walk stalls. It then fills all four slots with requests in the context order 2, 2, 3, 2 and squashes context 2. At that point the bench checks that the queue reports full, then that room reopens after the drop, and that only the in-flight walk and the context-3 walk answer. Write-back correctness is checked by comparing the bench's memory image with the reference image after all walks finish.

// File: rtl/pw_pkg.sv
// Shared types for the page table walker: result bundle, fault codes,
// descriptor classification and walk states.
package pw_pkg;

    typedef struct packed {
        logic [31:0] paddr;
        logic [2:0]  ap;
        logic [3:0]  domain;
        logic        xn;
        logic        glob;
        logic        share;
        logic [4:0]  attr;
    } pw_result_t;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_L1    = 2'd1,
        FLT_L2    = 2'd2,
        FLT_SUPER = 2'd3
    } pw_fault_e;

    typedef enum logic [1:0] {
        DK_MAP   = 2'd0,
        DK_TABLE = 2'd1,
        DK_FAULT = 2'd2
    } pw_kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_WRITEBACK, S_DONE
    } pw_state_e;

endpackage

// File: rtl/pw_queue.sv
// Pending-walk queue: an in-order circular buffer whose low KEY_W bits of
// each entry are a context key. A squash marks matching occupied entries;
// marked entries at the head are discarded, at most MAX_DROP per cycle, and
// never offered to the consumer.
// Assumes QDEPTH is a power of two and at least 2.
module pw_queue #(
    parameter int DATA_W   = 42,
    parameter int KEY_W    = 8,
    parameter int QDEPTH   = 4,
    parameter int MAX_DROP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              sq_valid,
    input  logic [KEY_W-1:0]  sq_key,
    output logic              head_valid,
    output logic [DATA_W-1:0] head_data,
    input  logic              take
);
    localparam int PTR_W   = $clog2(QDEPTH);
    localparam int CNT_W   = $clog2(QDEPTH + 1);
    localparam int SCAN    = (MAX_DROP < QDEPTH) ? MAX_DROP : QDEPTH;
    localparam int OUT_MAX = (MAX_DROP > 1) ? MAX_DROP : 1;

    logic [DATA_W-1:0] slot [QDEPTH];
    logic [QDEPTH-1:0] dead;
    logic [QDEPTH-1:0] occ;
    logic [PTR_W-1:0]  head, tail;
    logic [CNT_W-1:0]  count, drop_n, pop_n;
    logic              push;

    // Which physical slots currently hold a waiting entry.
    always_comb begin
        for (int i = 0; i < QDEPTH; i++) begin
            logic [PTR_W-1:0] off;
            off    = PTR_W'(i) - head;
            occ[i] = CNT_W'(off) < count;
        end
    end

    // Count the run of squashed entries at the head, bounded by MAX_DROP.
    always_comb begin
        logic run;
        run    = 1'b1;
        drop_n = '0;
        for (int k = 0; k < SCAN; k++) begin
            logic [PTR_W-1:0] idx;
            idx = head + PTR_W'(k);
            if (run && (CNT_W'(k) < count) && dead[idx])
                drop_n = drop_n + 1'b1;
            else
                run = 1'b0;
        end
    end

    assign in_ready   = count < CNT_W'(QDEPTH);
    assign head_valid = (count != '0) && !dead[head];
    assign head_data  = slot[head];
    assign push       = in_valid && in_ready;
    assign pop_n      = drop_n + CNT_W'(take && head_valid);

    // Pointer, occupancy and squash-mark bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
            dead  <= '0;
        end else begin
            head  <= head + PTR_W'(pop_n);
            tail  <= tail + PTR_W'(push);
            count <= count + CNT_W'(push) - pop_n;
            for (int i = 0; i < QDEPTH; i++)
                if (sq_valid && occ[i] && slot[i][KEY_W-1:0] == sq_key)
                    dead[i] <= 1'b1;
            if (push)
                dead[tail] <= 1'b0;
        end
    end

    // Entry storage, written at the tail.
    always_ff @(posedge clk) begin
        if (push)
            slot[tail] <= in_data;
    end

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(QDEPTH));

    // R10
    drop_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'($past(count)) - int'(count) <= OUT_MAX);

endmodule

// File: rtl/pw_addr.sv
// Descriptor address generation for both table levels. The first-level
// index width shrinks by BASE_N bits as the table base grows (BASE_N 0..7).
module pw_addr #(
    parameter int BASE_N = 0
) (
    input  logic [31:0] ttb,
    input  logic [31:0] va,
    input  logic [31:0] l1_desc,
    output logic [31:0] l1_addr,
    output logic [31:0] l2_addr
);
    localparam int TTB_LO = 14 - BASE_N;
    localparam int VA_HI  = 31 - BASE_N;

    logic unused_addr_bits;

    // First-level slot and second-level slot addresses.
    assign l1_addr = {ttb[31:TTB_LO], va[VA_HI:20], 2'b00};
    assign l2_addr = {l1_desc[31:10], va[19:12], 2'b00};

    generate
        if (BASE_N > 0) begin : g_hi
            assign unused_addr_bits = ^{ttb[TTB_LO-1:0], va[31:VA_HI+1], va[11:0], l1_desc[9:0]};
        end else begin : g_lo
            assign unused_addr_bits = ^{ttb[TTB_LO-1:0], va[11:0], l1_desc[9:0]};
        end
    endgenerate

endmodule

// File: rtl/pw_decode.sv
// Descriptor decoder. Classifies one fetched descriptor (first or second
// level), extracts the mapping fields and forms the write-back image with
// the access flag set. Purely combinational.
module pw_decode
    import pw_pkg::*;
(
    input  logic        l2_mode,
    input  logic [31:0] desc,
    input  logic [31:0] va,
    input  logic [3:0]  l1_dom,
    output pw_kind_e    kind,
    output pw_fault_e   fault,
    output pw_result_t  res,
    output logic        flag_clear,
    output logic [31:0] wb_data
);
    logic unused_va_hi;
    assign unused_va_hi = ^va[31:20];

    // Decode the descriptor according to its level and type bits.
    always_comb begin
        kind       = DK_FAULT;
        fault      = FLT_NONE;
        res        = '0;
        flag_clear = 1'b0;
        wb_data    = desc;
        if (!l2_mode) begin
            unique case (desc[1:0])
                2'b01: kind = DK_TABLE;
                2'b10: begin
                    if (desc[18]) begin
                        fault = FLT_SUPER;
                    end else begin
                        kind        = DK_MAP;
                        flag_clear  = !desc[10];
                        wb_data[10] = 1'b1;
                        res.paddr   = {desc[31:20], va[19:0]};
                        res.ap      = {desc[15], desc[11], 1'b1};
                        res.domain  = desc[8:5];
                        res.xn      = desc[4];
                        res.glob    = desc[17];
                        res.share   = desc[16];
                        res.attr    = {desc[14:12], desc[3], desc[2]};
                    end
                end
                default: fault = FLT_L1;
            endcase
        end else if (desc[1:0] == 2'b00) begin
            fault = FLT_L2;
        end else begin
            kind       = DK_MAP;
            flag_clear = !desc[4];
            wb_data[4] = 1'b1;
            res.ap     = {desc[9], desc[5], 1'b1};
            res.domain = l1_dom;
            res.glob   = !desc[11];
            res.share  = desc[10];
            if (!desc[1]) begin
                res.paddr = {desc[31:16], va[15:0]};
                res.xn    = desc[15];
                res.attr  = {desc[14:12], desc[3], desc[2]};
            end else begin
                res.paddr = {desc[31:12], va[11:0]};
                res.xn    = desc[0];
                res.attr  = {desc[8:6], desc[3], desc[2]};
            end
        end
    end

endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker top. Holds the pending queue, the walk state
// machine and the result registers. Assumes memory answers every access
// (read or write) with one mem_rsp_valid pulse no earlier than the cycle
// after the request, and that one access is outstanding at a time.
module pt_walker
    import pw_pkg::*;
#(
    parameter int CTX_W    = 8,
    parameter int QDEPTH   = 4,
    parameter int MAX_DROP = 2,
    parameter int BASE_N   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      ttb_base,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_vaddr,
    input  logic             req_write,
    input  logic             req_fetch,
    input  logic [CTX_W-1:0] req_ctx,
    input  logic             squash_valid,
    input  logic [CTX_W-1:0] squash_ctx,
    output logic             mem_req_valid,
    output logic             mem_req_write,
    output logic [31:0]      mem_req_addr,
    output logic [31:0]      mem_req_wdata,
    input  logic             mem_rsp_valid,
    input  logic [31:0]      mem_rsp_rdata,
    output logic             rsp_valid,
    output logic [CTX_W-1:0] rsp_ctx,
    output logic             rsp_write,
    output logic             rsp_fetch,
    output logic [1:0]       rsp_fault,
    output logic [31:0]      rsp_paddr,
    output logic [2:0]       rsp_ap,
    output logic [3:0]       rsp_domain,
    output logic             rsp_xn,
    output logic             rsp_global,
    output logic             rsp_share,
    output logic [4:0]       rsp_attr
);
    localparam int ENT_W = 32 + 2 + CTX_W;

    pw_state_e         state;
    logic [ENT_W-1:0]  q_in, q_head;
    logic              q_head_valid, q_take;
    logic [31:0]       cur_va;
    logic              cur_wr, cur_fe;
    logic [CTX_W-1:0]  cur_ctx;
    logic [31:0]       l1desc_q, l1_addr, l2_addr;
    logic [31:0]       wb_addr_q, wb_data_q;
    logic              wb_sent, wb_l2_q;
    pw_result_t        res_q, dec_res;
    pw_fault_e         fault_q, dec_fault;
    pw_kind_e          dec_kind;
    logic              dec_flag_clear;
    logic [31:0]       dec_wb;
    logic              unused_l1_bits;

    assign q_in   = {req_vaddr, req_write, req_fetch, req_ctx};
    assign q_take = (state == S_IDLE) && q_head_valid;

    pw_queue #(
        .DATA_W(ENT_W), .KEY_W(CTX_W), .QDEPTH(QDEPTH), .MAX_DROP(MAX_DROP)
    ) u_queue (
        .clk(clk), .rst_n(rst_n),
        .in_valid(req_valid), .in_ready(req_ready), .in_data(q_in),
        .sq_valid(squash_valid), .sq_key(squash_ctx),
        .head_valid(q_head_valid), .head_data(q_head), .take(q_take)
    );

    pw_addr #(.BASE_N(BASE_N)) u_addr (
        .ttb(ttb_base), .va(cur_va), .l1_desc(l1desc_q),
        .l1_addr(l1_addr), .l2_addr(l2_addr)
    );

    pw_decode u_decode (
        .l2_mode(state == S_L2_WAIT), .desc(mem_rsp_rdata), .va(cur_va),
        .l1_dom(l1desc_q[8:5]), .kind(dec_kind), .fault(dec_fault),
        .res(dec_res), .flag_clear(dec_flag_clear), .wb_data(dec_wb)
    );

    assign unused_l1_bits = ^{l1desc_q[9], l1desc_q[4:2]};

    // Walk sequencing: fetch, decode, optional write-back, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cur_va    <= '0;
            cur_wr    <= 1'b0;
            cur_fe    <= 1'b0;
            cur_ctx   <= '0;
            l1desc_q  <= '0;
            wb_addr_q <= '0;
            wb_data_q <= '0;
            wb_sent   <= 1'b0;
            wb_l2_q   <= 1'b0;
            res_q     <= '0;
            fault_q   <= FLT_NONE;
        end else begin
            unique case (state)
                S_IDLE: if (q_head_valid) begin
                    {cur_va, cur_wr, cur_fe, cur_ctx} <= q_head;
                    state <= S_L1_REQ;
                end
                S_L1_REQ: state <= S_L1_WAIT;
                S_L2_REQ: state <= S_L2_WAIT;
                S_L1_WAIT, S_L2_WAIT: if (mem_rsp_valid) begin
                    if (state == S_L1_WAIT) l1desc_q <= mem_rsp_rdata;
                    res_q     <= dec_res;
                    fault_q   <= dec_fault;
                    wb_data_q <= dec_wb;
                    wb_addr_q <= (state == S_L1_WAIT) ? l1_addr : l2_addr;
                    wb_l2_q   <= (state == S_L2_WAIT);
                    wb_sent   <= 1'b0;
                    if (dec_kind == DK_TABLE)
                        state <= S_L2_REQ;
                    else if (dec_kind == DK_MAP && dec_flag_clear)
                        state <= S_WRITEBACK;
                    else
                        state <= S_DONE;
                end
                S_WRITEBACK: begin
                    if (!wb_sent)
                        wb_sent <= 1'b1;
                    else if (mem_rsp_valid)
                        state <= S_DONE;
                end
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Memory port: one request cycle per read, one for the write-back.
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        if (state == S_L1_REQ) begin
            mem_req_valid = 1'b1;
            mem_req_addr  = l1_addr;
        end else if (state == S_L2_REQ) begin
            mem_req_valid = 1'b1;
            mem_req_addr  = l2_addr;
        end else if (state == S_WRITEBACK && !wb_sent) begin
            mem_req_valid = 1'b1;
            mem_req_write = 1'b1;
            mem_req_addr  = wb_addr_q;
            mem_req_wdata = wb_data_q;
        end
    end

    // Result port, driven from the walk registers in the DONE state.
    assign rsp_valid  = (state == S_DONE);
    assign rsp_ctx    = cur_ctx;
    assign rsp_write  = cur_wr;
    assign rsp_fetch  = cur_fe;
    assign rsp_fault  = fault_q;
    assign rsp_paddr  = res_q.paddr;
    assign rsp_ap     = res_q.ap;
    assign rsp_domain = res_q.domain;
    assign rsp_xn     = res_q.xn;
    assign rsp_global = res_q.glob;
    assign rsp_share  = res_q.share;
    assign rsp_attr   = res_q.attr;

    // R11
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11
    mem_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R3
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0 && rsp_ap == '0));

    // R6
    l2_after_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && state == S_L2_REQ) |-> (l1desc_q[1:0] == 2'b01));

    // R9
    wb_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |->
            (wb_l2_q ? mem_req_wdata[4] : mem_req_wdata[10]));

endmodule

// File: tb/pt_walker_bench.sv
// Self-checking bench: behavioural reference walk over a model memory image,
// a latency-configurable memory responder and per-clock result comparison.
module pt_walker_bench;
    localparam logic [31:0] TTB = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [7:0]  req_ctx = '0, squash_ctx = '0;
    logic        squash_valid = 1'b0;
    logic        req_ready;
    logic        mem_req_valid, mem_req_write;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        rsp_valid, rsp_write, rsp_fetch, rsp_xn, rsp_global, rsp_share;
    logic [7:0]  rsp_ctx;
    logic [1:0]  rsp_fault;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_ap;
    logic [3:0]  rsp_domain;
    logic [4:0]  rsp_attr;

    int checks = 0, fails = 0, cycles = 0, lat = 2;
    bit done = 0;

    always #4 clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n), .ttb_base(TTB),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_fetch(req_fetch), .req_ctx(req_ctx),
        .squash_valid(squash_valid), .squash_ctx(squash_ctx),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .rsp_valid(rsp_valid), .rsp_ctx(rsp_ctx), .rsp_write(rsp_write),
        .rsp_fetch(rsp_fetch), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .rsp_ap(rsp_ap), .rsp_domain(rsp_domain), .rsp_xn(rsp_xn),
        .rsp_global(rsp_global), .rsp_share(rsp_share), .rsp_attr(rsp_attr)
    );

    typedef struct {
        logic [7:0]  ctx;
        logic        wr, fe;
        logic [1:0]  fault;
        logic [31:0] pa;
        logic [2:0]  ap;
        logic [3:0]  dom;
        logic        xn, g, sh;
        logic [4:0]  attr;
        int          rq;
    } exp_t;

    exp_t expq[$];
    logic [31:0] dmem [logic [31:0]];
    logic [31:0] mmem [logic [31:0]];

    function automatic logic [31:0] mrd(input logic [31:0] a);
        return mmem.exists(a) ? mmem[a] : 32'h0;
    endfunction

    task automatic put(input logic [31:0] a, input logic [31:0] d);
        mmem[a] = d;
        dmem[a] = d;
    endtask

    task automatic check(input bit ok, input int rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Reference walk over the model memory (requirements R2..R9).
    function automatic exp_t ref_walk(input logic [31:0] va, input logic [7:0] ctx,
                                      input logic wr, input logic fe);
        exp_t e;
        logic [31:0] a1, d1, a2, d2;
        logic [2:0] tex;
        e = '{ctx: ctx, wr: wr, fe: fe, fault: 2'd0, pa: 32'h0, ap: 3'h0, dom: 4'h0,
              xn: 1'b0, g: 1'b0, sh: 1'b0, attr: 5'h0, rq: 4};
        a1 = TTB + {18'h0, va[31:20], 2'b00};
        d1 = mrd(a1);
        if (d1[1:0] == 2'd0 || d1[1:0] == 2'd3) begin
            e.fault = 2'd1; e.rq = 3;
        end else if (d1[1:0] == 2'd2 && d1[18]) begin
            e.fault = 2'd3; e.rq = 5;
        end else if (d1[1:0] == 2'd2) begin
            if (!d1[10]) begin d1[10] = 1'b1; mmem[a1] = d1; end
            e.pa = {d1[31:20], va[19:0]};
            e.ap = {d1[15], d1[11:10]};
            e.dom = d1[8:5]; e.xn = d1[4]; e.g = d1[17]; e.sh = d1[16];
            e.attr = {d1[14:12], d1[3:2]};
        end else begin
            a2 = {d1[31:10], 10'h0} + {22'h0, va[19:12], 2'b00};
            d2 = mrd(a2);
            if (d2[1:0] == 2'd0) begin
                e.fault = 2'd2; e.rq = 6;
            end else begin
                if (!d2[4]) begin d2[4] = 1'b1; mmem[a2] = d2; end
                e.ap = {d2[9], d2[5:4]};
                e.dom = d1[8:5]; e.g = ~d2[11]; e.sh = d2[10];
                if (d2[1] == 1'b0) begin
                    e.rq = 7; e.pa = (d2 & 32'hFFFF_0000) | (va & 32'h0000_FFFF);
                    e.xn = d2[15]; tex = d2[14:12];
                end else begin
                    e.rq = 8; e.pa = (d2 & 32'hFFFF_F000) | (va & 32'h0000_0FFF);
                    e.xn = d2[0]; tex = d2[8:6];
                end
                e.attr = {tex, d2[3:2]};
            end
        end
        return e;
    endfunction

    task automatic send(input logic [31:0] va, input logic [7:0] ctx,
                        input logic wr, input logic fe);
        while (!req_ready) begin @(posedge clk); #1; end
        expq.push_back(ref_walk(va, ctx, wr, fe));
        req_valid = 1'b1; req_vaddr = va; req_ctx = ctx;
        req_write = wr; req_fetch = fe;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (expq.size() != 0) begin @(posedge clk); #1; end
        repeat (4) @(posedge clk);
        #1;
    endtask

    // Memory responder with programmable latency.
    bit mbusy = 0, mwr = 0;
    int mcnt = 0;
    logic [31:0] maddr, mwdata;
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (mbusy) begin
            if (mcnt <= 0) begin
                mem_rsp_valid = 1'b1;
                if (mwr) begin dmem[maddr] = mwdata; mem_rsp_rdata = '0; end
                else mem_rsp_rdata = dmem.exists(maddr) ? dmem[maddr] : 32'h0;
                mbusy = 0;
            end else mcnt--;
        end else if (mem_req_valid && rst_n) begin
            mbusy = 1; mcnt = lat - 1; mwr = mem_req_write;
            maddr = mem_req_addr; mwdata = mem_req_wdata;
        end
    end

    // Per-clock comparison of the result port against the reference queue.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, 11, "unexpected rsp_valid", 64'(rsp_ctx), 64'h0);
            end else begin
                exp_t e;
                logic [63:0] act, exv;
                e = expq.pop_front();
                act = {rsp_ctx, rsp_write, rsp_fetch, rsp_fault, rsp_paddr, rsp_ap,
                       rsp_domain, rsp_xn, rsp_global, rsp_share, rsp_attr, 3'b0};
                exv = {e.ctx, e.wr, e.fe, e.fault, e.pa, e.ap,
                       e.dom, e.xn, e.g, e.sh, e.attr, 3'b0};
                check(act == exv, e.rq, "walk result", act, exv);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL R11 watchdog expired actual=%0d expected=<50000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // first-level image
        put(TTB + 4*1,  32'h1230_0000 | (1<<17) | (1<<15) | (5<<12) | (1<<11)
                        | (4'hA<<5) | (1<<4) | (1<<2) | 2);
        put(TTB + 4*2,  32'h4560_0000 | (1<<16) | (1<<10) | (3<<5) | (1<<3) | 2);
        put(TTB + 4*3,  32'h7800_0000 | (1<<18) | 2);
        put(TTB + 4*4,  32'h0);
        put(TTB + 4*5,  32'h0000_0C03);
        put(TTB + 4*6,  32'h0002_0400 | (9<<5) | 1);
        put(TTB + 4*12, 32'h0003_0000 | (2<<5) | 1);
        for (int i = 7; i <= 11; i++)
            put(TTB + 4*i, (i << 20) | (1<<10) | (1<<5) | 2);
        // second-level image for the table at 0x20400
        put(32'h0002_0400 + 4*8'h10, 32'hBEEF_0000 | (1<<15) | (6<<12) | (1<<11)
                                     | (1<<10) | (1<<9) | (1<<5) | (1<<2) | 1);
        put(32'h0002_0400 + 4*8'h11, 32'hCAFE_B000 | (1<<10) | (5<<6) | (1<<5)
                                     | (1<<3) | 3);
        put(32'h0002_0400 + 4*8'h12, 32'h1357_9000 | (1<<11) | (1<<9) | (1<<4)
                                     | (2<<6) | 2);
        put(32'h0002_0400 + 4*8'h13, 32'h0000_0FFC);

        repeat (3) @(posedge clk);
        #1;
        // R12 reset state
        check(rsp_valid == 1'b0, 12, "rsp_valid in reset", 64'(rsp_valid), 64'h0);
        check(mem_req_valid == 1'b0, 12, "mem_req_valid in reset", 64'(mem_req_valid), 64'h0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(req_ready == 1'b1, 12, "req_ready after reset", 64'(req_ready), 64'h1);

        // R4 section, flag clear -> R9 write-back; R2 index from va[31:20]
        send(32'h0011_2345, 8'h11, 1'b1, 1'b0);
        // R4 section, flag already set
        send(32'h002A_BCDE, 8'h12, 1'b0, 1'b1);
        // R5 supersection
        send(32'h0030_0000, 8'h13, 1'b0, 1'b0);
        // R3 invalid and reserved first-level types, and an unmapped slot
        send(32'h0040_0001, 8'h14, 1'b1, 1'b1);
        send(32'h0050_0000, 8'h15, 1'b0, 1'b0);
        send(32'h7FF0_0000, 8'h16, 1'b0, 1'b0);
        // R7 large page with flag clear (R9), R8 small pages
        send(32'h0061_0ABC, 8'h21, 1'b0, 1'b0);
        send(32'h0061_1FED, 8'h22, 1'b1, 1'b0);
        send(32'h0061_2004, 8'h23, 1'b0, 1'b1);
        // R6 invalid second-level entries
        send(32'h0061_3000, 8'h24, 1'b0, 1'b0);
        send(32'h00C0_5000, 8'h25, 1'b0, 1'b0);
        // R9 repeat uses see the flag already set: no second write-back
        send(32'h0011_FFFF, 8'h26, 1'b0, 1'b0);
        send(32'h0061_0001, 8'h27, 1'b0, 1'b0);
        drain();

        // R10 squash while a slow walk holds the walker
        lat = 20;
        send(32'h0070_0000, 8'h01, 1'b0, 1'b0);
        repeat (2) @(posedge clk);
        #1;
        send(32'h0080_0000, 8'h02, 1'b0, 1'b0);
        send(32'h0090_0000, 8'h02, 1'b0, 1'b0);
        send(32'h00A0_0000, 8'h03, 1'b0, 1'b0);
        send(32'h00B0_0000, 8'h02, 1'b0, 1'b0);
        // R1 queue full with QDEPTH waiting
        check(req_ready == 1'b0, 1, "req_ready when full", 64'(req_ready), 64'h0);
        squash_valid = 1'b1; squash_ctx = 8'h02;
        for (int i = expq.size() - 1; i >= 1; i--)
            if (expq[i].ctx == 8'h02) expq.delete(i);
        for (int i = 1; i < expq.size(); i++) expq[i].rq = 10;
        @(posedge clk); #1;
        squash_valid = 1'b0;
        @(posedge clk); #1;
        // R10 dead entries leave the head, room reopens
        check(req_ready == 1'b1, 10, "req_ready after squash drop", 64'(req_ready), 64'h1);
        lat = 2;
        drain();
        check(expq.size() == 0, 10, "pending results", 64'(expq.size()), 64'h0);

        // R9 memory image after all write-backs
        check(dmem.num() == mmem.num(), 9, "memory entry count", 64'(dmem.num()), 64'(mmem.num()));
        foreach (mmem[a]) begin
            logic [31:0] got;
            got = dmem.exists(a) ? dmem[a] : 32'hDEAD_DEAD;
            check(got == mmem[a], 9, "descriptor image", {a, got}, {a, mmem[a]});
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule